// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a word-addressed timer that a small processor uses for its periodic operating-system tick. Software writes a reload value, picks a count source and turns the timer on. The counter then steps down once per selected tick. When it reaches the end of a period it sets a sticky expiry flag. If interrupts are enabled, it also sends a one-cycle request pulse to the interrupt controller.

There are two count sources. The core clock steps the counter on every cycle. The slower reference source steps it only on cycles where the single-cycle `ref_tick` enable is high. Software can stop the count and later resume it from where it stopped. Software can restart the count by writing the current-value word. A reload of zero turns the timer into a single-shot that switches itself off after one expiry. The register interface is a simple strobe bus: `bus_sel` with `bus_wr` performs a write in one cycle, and `bus_sel` without `bus_wr` returns read data combinationally in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, reload word and current-value word all read 0, and `irq_pulse` is low.
- R2: The control word is at byte offset 0x10 and has these fields: bit 0 enable, bit 1 interrupt enable, bit 2 source (1 = core clock every cycle, 0 = `ref_tick`), bit 16 expiry flag. Other bits read 0. A write changes only bits 2:0, and software cannot set the flag. The reload word is at 0x14. It keeps the low CNT_W bits of the written data and reads zero-extended.
- R3: While enabled, the counter steps once per selected tick. The current value read at 0x18 runs from the reload value down to 0, and each expiry is reload+1 steps after the previous one. The value reads 0 during the final step before expiry.
- R4: At expiry the flag is set. When bit 1 is 1, `irq_pulse` is high for exactly the one cycle after the expiring step. When bit 1 is 0, `irq_pulse` stays low.
- R5: A read of the control word returns the flag and clears it. If an expiry occurs in the same cycle as the read, the flag stays set.
- R6: If the reload value is 0 at expiry, the enable bit clears itself after that one expiry. Otherwise the counter reloads and keeps running.
- R7: Any write to 0x18 restarts the count from the reload value and clears the flag. The written data has no effect.
- R8: The current-value word reads 0 while the enable bit is 0.
- R9: Re-enabling after a disable resumes from the remaining count. The first enable after reset starts from the reload value.
- R10: A control write that leaves the enable bit unchanged but changes the source bit restarts the count from the reload value.
- R11: No counting step happens in a cycle that writes the control word or the current-value word.
- R12: Offset 0x1C always reads CAL_VALUE (10000 by default). Writes to 0x1C and to unmapped offsets change no state, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Single-cycle reference tick enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| irq_pulse | output | 1 | One-cycle request to the interrupt controller |

## Verification
The bench builds the block with CNT_W = 12, so an all-ones reload write visibly loses its upper bits. CAL_VALUE keeps its default of 10000. Random reload values stay mostly between 0 and 5, so expiries, single-shot shutdowns and bus collisions with an expiring step (read-clear against set, restart against step) happen within a few cycles of each other. `ref_tick` is driven randomly about one cycle in three, so both count sources and source-change restarts are covered alongside the directed resume and hold sequences.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_RELOAD = 8'h14;
  localparam logic [7:0] OFS_CUR    = 8'h18;
  localparam logic [7:0] OFS_CAL    = 8'h1C;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_bits_t;

  function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_bits_t c, input logic flag);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_EN]   = c.run;
    w[BIT_IE]   = c.irq_en;
    w[BIT_SRC]  = c.src_core;
    w[BIT_FLAG] = flag;
    return w;
  endfunction

endpackage

// File: rtl/tt_tick_sel.sv
module tt_tick_sel (
  input  logic run,
  input  logic src_core,
  input  logic ref_tick,
  input  logic hold,
  output logic step
);
  logic src_pulse;

  assign src_pulse = src_core | ref_tick;
  assign step      = run & src_pulse & ~hold;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             load_req,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             loaded,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] rl);
    return (cur == '0) ? rl : cur - ONE;
  endfunction

  assign expire = step & ~load_req & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      loaded <= 1'b0;
    end else if (load_req) begin
      cnt    <= reload_val;
      loaded <= 1'b1;
    end else if (step) begin
      cnt <= next_count(cnt, reload_val);
    end
  end

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> cnt == $past(reload_val));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_req && cnt != '0) |=> cnt == $past(cnt) - ONE);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(reload_val));
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  ctrl_bits_t wr_bits,
  input  logic       rd_ctrl,
  input  logic       wr_cur,
  input  logic       expire,
  input  logic       reload_zero,
  output ctrl_bits_t ctrl,
  output logic       flag,
  output logic       irq_pulse,
  output logic       en_rise,
  output logic       src_restart
);
  assign en_rise     = wr_ctrl & wr_bits.run & ~ctrl.run;
  assign src_restart = wr_ctrl & (wr_bits.run == ctrl.run) & (wr_bits.src_core != ctrl.src_core);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      flag      <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (wr_ctrl)                    ctrl     <= wr_bits;
      else if (expire && reload_zero) ctrl.run <= 1'b0;

      if (expire)                flag <= 1'b1;
      else if (rd_ctrl || wr_cur) flag <= 1'b0;

      irq_pulse <= expire & ctrl.irq_en;
    end
  end

  assert_oneshot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_zero) |=> !ctrl.run);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ctrl || wr_cur) && !expire) |=> !flag);

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse
);
  localparam int PAD_W = WORD_W - CNT_W;

  logic hit_ctrl, hit_reload, hit_cur, hit_cal;
  logic wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic step, expire, load_req, loaded, flag, en_rise, src_restart;
  logic [CNT_W-1:0] reload_q, cnt;
  ctrl_bits_t ctrl, wr_bits;
  logic unused_wdata;

  assign hit_ctrl   = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_reload = bus_addr == ADDR_W'(OFS_RELOAD);
  assign hit_cur    = bus_addr == ADDR_W'(OFS_CUR);
  assign hit_cal    = bus_addr == ADDR_W'(OFS_CAL);

  assign wr_ctrl   = bus_sel & bus_wr & hit_ctrl;
  assign wr_reload = bus_sel & bus_wr & hit_reload;
  assign wr_cur    = bus_sel & bus_wr & hit_cur;
  assign rd_ctrl   = bus_sel & ~bus_wr & hit_ctrl;

  assign wr_bits      = ctrl_bits_t'(bus_wdata[2:0]);
  assign unused_wdata = ^bus_wdata[WORD_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
  end

  assign load_req = wr_cur | src_restart | (en_rise & ~loaded);

  tt_tick_sel u_sel (
    .run      (ctrl.run),
    .src_core (ctrl.src_core),
    .ref_tick (ref_tick),
    .hold     (wr_ctrl | wr_cur),
    .step     (step)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_val (reload_q),
    .load_req   (load_req),
    .step       (step),
    .cnt        (cnt),
    .loaded     (loaded),
    .expire     (expire)
  );

  tt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_bits     (wr_bits),
    .rd_ctrl     (rd_ctrl),
    .wr_cur      (wr_cur),
    .expire      (expire),
    .reload_zero (reload_q == '0),
    .ctrl        (ctrl),
    .flag        (flag),
    .irq_pulse   (irq_pulse),
    .en_rise     (en_rise),
    .src_restart (src_restart)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ctrl)        bus_rdata = pack_ctrl(ctrl, flag);
      else if (hit_reload) bus_rdata = {{PAD_W{1'b0}}, reload_q};
      else if (hit_cur)    bus_rdata = ctrl.run ? {{PAD_W{1'b0}}, cnt} : '0;
      else if (hit_cal)    bus_rdata = CAL_VALUE;
    end
  end

  assert_hold_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl || wr_cur) |-> !step);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CW = 12;
  localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;
  localparam logic [31:0] CAL = 32'd10000;

  logic clk = 0, rst_n = 0, ref_tick = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_pulse;
  int n_chk = 0, n_err = 0;
  logic rand_ref = 0, started = 0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CW), .ADDR_W(8), .CAL_VALUE(CAL)) i_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse));

  // reference model state, built from the requirements
  logic m_en, m_ie, m_src, m_flag, m_loaded, m_irq;
  logic [CW-1:0] m_reload, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic wc, wcur, wrl, rc, stp, ex;
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_loaded = 0; m_irq = 0;
      m_reload = '0; m_cnt = '0;
    end else begin
      wc   = bus_sel && bus_wr && bus_addr == A_CTRL;
      wcur = bus_sel && bus_wr && bus_addr == A_CUR;
      wrl  = bus_sel && bus_wr && bus_addr == A_RLD;
      rc   = bus_sel && !bus_wr && bus_addr == A_CTRL;
      stp  = m_en && (m_src || ref_tick) && !wc && !wcur;      // R11
      ex   = stp && m_cnt == 0;
      m_irq = ex && m_ie;                                       // R4
      if (ex) m_flag = 1; else if (rc || wcur) m_flag = 0;      // R5 R7
      if (wc) begin
        if (bus_wdata[0] && !m_en && !m_loaded) begin m_cnt = m_reload; m_loaded = 1; end   // R9
        else if (bus_wdata[0] == m_en && bus_wdata[2] != m_src) begin m_cnt = m_reload; m_loaded = 1; end // R10
        m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
      end
      if (wcur) begin m_cnt = m_reload; m_loaded = 1; end
      if (ex) begin m_cnt = m_reload; if (m_reload == 0) m_en = 0; end  // R6
      else if (stp) m_cnt = m_cnt - 1'b1;
      if (wrl) m_reload = bus_wdata[CW-1:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      A_CTRL:  return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
      A_RLD:   return 32'(m_reload);
      A_CUR:   return m_en ? 32'(m_cnt) : 32'd0;
      A_CAL:   return CAL;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    string tag;
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    tag = (a == A_CTRL) ? "R5 ctrl read" : (a == A_CUR) ? "R3 current read" :
          (a == A_RLD) ? "R2 reload read" : "R12 fixed read";
    check(tag, d, exp_read(a));
    @(posedge clk); #1 bus_sel = 0;
  endtask

  // every cycle: interrupt pulse against the model (R4)
  always @(posedge clk) begin
    #4;
    if (rst_n && started) check("R4 irq_pulse", 32'(irq_pulse), 32'(m_irq));
  end

  always @(negedge clk) ref_tick <= rand_ref ? (($urandom % 3) == 0) : 1'b0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, v;
    int n, seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1; started = 1;

    // R1 R12 reset state
    bus_read(A_CTRL, d); check("R1 ctrl after reset", d, 0);
    bus_read(A_RLD, d);  check("R1 reload after reset", d, 0);
    bus_read(A_CUR, d);  check("R1 current after reset", d, 0);
    bus_read(A_CAL, d);  check("R12 calibration", d, CAL);
    check("R1 irq after reset", 32'(irq_pulse), 0);

    // R9 first enable loads reload
    bus_write(A_RLD, 20);
    bus_write(A_CTRL, 32'h5);
    bus_read(A_CUR, d); check("R9 first enable from reload", d, 20);

    // R11 control write holds the count
    repeat (3) @(negedge clk);
    bus_read(A_CUR, v);
    bus_write(A_CTRL, 32'h7);
    bus_read(A_CUR, d); check("R11 no step on ctrl write", d, v - 1);

    // R8 R9 disable then resume
    bus_read(A_CUR, v);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CUR, d); check("R8 current while disabled", d, 0);
    bus_write(A_CTRL, 32'h5);
    bus_read(A_CUR, d); check("R9 resume remaining", d, v - 1);

    // R10 source change restarts
    bus_write(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(A_CUR, d); check("R10 source change restart", d, 20);

    // R2 width and writable bits
    bus_write(A_RLD, 32'hFFFF_FFFF);
    bus_read(A_RLD, d); check("R2 reload truncation", d, 32'hFFF);
    bus_write(A_CTRL, 32'hFFFF_FFF8);
    bus_read(A_CTRL, d); check("R2 only low bits writable", d, 0);

    // R3 period reload+1
    bus_write(A_RLD, 3);
    bus_write(A_CUR, 0);
    bus_write(A_CTRL, 32'h7);
    n = 0;
    while (!irq_pulse && n < 50) begin @(posedge clk); #4; n++; end
    n = 0;
    do begin @(posedge clk); #4; n++; end while (!irq_pulse && n < 50);
    check("R3 period cycles", n, 4);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, d); check("R4 flag set by expiry", d, 32'h0001_0000);
    bus_read(A_CTRL, d); check("R5 flag cleared by read", d, 0);

    // R4 no pulse with interrupt disabled, R7 restart clears flag
    bus_write(A_RLD, 1);
    bus_write(A_CTRL, 32'h5);
    n = 0;
    repeat (6) begin @(posedge clk); #4; if (irq_pulse) n++; end
    check("R4 no pulse when disabled", n, 0);
    bus_write(A_CUR, 32'h123);
    bus_read(A_CTRL, d); check("R7 restart clears flag", d, 32'h5);
    bus_read(A_CUR, d);  check("R3 zero in final step", d, 0);

    // R6 single shot
    bus_write(A_CTRL, 32'h0);
    bus_write(A_RLD, 0);
    bus_write(A_CUR, 0);
    bus_write(A_CTRL, 32'h7);
    repeat (2) @(negedge clk);
    bus_read(A_CTRL, d); check("R6 one shot disables", d, 32'h0001_0006);
    bus_read(A_CUR, d);  check("R6 current after one shot", d, 0);
    bus_read(A_CTRL, d); check("R5 flag gone after read", d, 32'h6);

    // random phase against the model
    rand_ref = 1;
    for (int i = 0; i < 700; i++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0, 1: bus_write(A_CTRL, $urandom);
        2:    bus_write(A_RLD, (($urandom % 8) == 0) ? $urandom : ($urandom % 6));
        3:    bus_write(A_CUR, $urandom);
        8:    bus_write((($urandom % 2) == 0) ? A_CAL : 8'h20 + 8'(4 * ($urandom % 8)), $urandom);
        9:    repeat ($urandom % 4) @(negedge clk);
        default: bus_read(8'h10 + 8'(4 * ($urandom % 5)), d);
      endcase
    end
    rand_ref = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule